// File: doc/BRIEF.md
# Fused-Immediate ALU for Undocumented 8-bit Operations

This block is a purely combinational execution slice for an 8-bit accumulator-style processor. It covers the seven unofficial operations that take an immediate operand or move data between registers. Each of them either merges a bitwise AND with a second step (a carry copy, a rotate, a logical shift or a subtraction) or loads several registers with one value. The slice receives the current accumulator (A), X index, stack pointer (SP) and status bits. It returns the next values of these, together with a write enable for each of A, X and SP.

The surrounding core decodes the opcode into `op_sel`, presents the operand byte, and commits the results in the same cycle. Instruction fetch, addressing, sequencing, decimal arithmetic and bus traffic are handled elsewhere.

Top module: `uopalu_top`

## Requirements
- R1: With `op_sel`=1 (AND-carry), A becomes A AND operand, C becomes bit 7 of that value, and only `a_we` is asserted.
- R2: With `op_sel`=2 (AND-rotate), t = A AND operand. A becomes {t[7], t[7:1]}, C becomes t[7], and only `a_we` is asserted.
- R3: With `op_sel`=3 (AND-shift), t = A AND operand. A becomes t shifted right logically by one, C becomes t[0], and only `a_we` is asserted.
- R4: With `op_sel`=4 (dual load), both A and X become the operand. `a_we` and `x_we` are asserted and `sp_we` is not. C is unchanged.
- R5: With `op_sel`=5 (stack-mask load), A, X and SP all become SP AND operand, and all three write enables are asserted. C is unchanged.
- R6: With `op_sel`=6 (masked subtract), X becomes the low 8 bits of (A AND X) minus operand. Only `x_we` is asserted, and A and SP are unchanged.
- R7: For `op_sel`=6, C is 1 exactly when (A AND X) is greater than or equal to the operand, whatever the value of `c_in`.
- R8: With `op_sel`=7 (X-mask load), A becomes X AND operand, and only `a_we` is asserted. C is unchanged.
- R9: With `op_sel` equal to 0 or 8 to 15, no write enable is asserted and every output equals its corresponding input.
- R10: For every supported op, N equals bit 7 of the value written (X for op 6, A otherwise), and Z is 1 exactly when that value is zero.
- R11: `v_out` equals `v_in` and `d_out` equals `d_in` for every `op_sel`.
- R12: Any register whose write enable is low has a next value equal to its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select (encodings in R1 to R9) |
| operand | input | 8 | Immediate operand byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X index |
| sp_in | input | 8 | Current stack pointer |
| c_in | input | 1 | Current carry |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| v_in | input | 1 | Current overflow flag |
| d_in | input | 1 | Current decimal flag |
| a_out | output | 8 | Next accumulator |
| x_out | output | 8 | Next X index |
| sp_out | output | 8 | Next stack pointer |
| a_we | output | 1 | Accumulator write enable |
| x_we | output | 1 | X write enable |
| sp_we | output | 1 | Stack pointer write enable |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry |
| v_out | output | 1 | Next overflow flag |
| d_out | output | 1 | Next decimal flag |

## Verification
The bench targets the masked subtract at equality and at a one-below borrow, each with both carry-in values. A design that used the incoming carry, or that inverted the borrow sense, would report the wrong C or be off by one in X. It applies AND-rotate and AND-shift with the masked value's bit 7 and bit 0 set. A design that mixed up the rotate and the shift, or that took C after the rotate, would then show the wrong top bit or the wrong carry. All unsupported encodings are driven with random register contents, which exposes any stray write enable or flag change. Results that are exactly zero or exactly 0x80 check the Z and N derivation for each op.

// File: rtl/uopalu_pkg.sv
package uopalu_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] OP_IDLE = 4'd0;
  localparam logic [SEL_W-1:0] OP_ANC  = 4'd1;
  localparam logic [SEL_W-1:0] OP_ARR  = 4'd2;
  localparam logic [SEL_W-1:0] OP_ASR  = 4'd3;
  localparam logic [SEL_W-1:0] OP_LAX  = 4'd4;
  localparam logic [SEL_W-1:0] OP_LAS  = 4'd5;
  localparam logic [SEL_W-1:0] OP_SBX  = 4'd6;
  localparam logic [SEL_W-1:0] OP_XAA  = 4'd7;

  typedef enum logic [1:0] {
    SH_PASS = 2'd0,
    SH_ROT  = 2'd1,
    SH_LSR  = 2'd2
  } shift_mode_e;

  // Rotate right with the old top bit fed back into the top
  function automatic logic [DATA_W-1:0] rot_keep_msb(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1], v[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] shr_logical(input logic [DATA_W-1:0] v);
    return {1'b0, v[DATA_W-1:1]};
  endfunction

  // Subtract with one extra bit; top bit set means a borrow occurred
  function automatic logic [DATA_W:0] sub_wide(input logic [DATA_W-1:0] lhs,
                                               input logic [DATA_W-1:0] rhs);
    return {1'b0, lhs} - {1'b0, rhs};
  endfunction
endpackage

// File: rtl/uopalu_shift.sv
module uopalu_shift
  import uopalu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] masked,
  input  shift_mode_e  mode,
  output logic [W-1:0] result,
  output logic         carry
);
  always_comb begin
    unique case (mode)
      SH_ROT: begin
        result = rot_keep_msb(masked);
        carry  = masked[W-1];
      end
      SH_LSR: begin
        result = shr_logical(masked);
        carry  = masked[0];
      end
      default: begin
        result = masked;
        carry  = masked[W-1];
      end
    endcase
  end

  always_comb begin
    if (mode == SH_ROT)
      assert_rot_top_is_carry_R2: assert (result[W-1] == carry);
    if (mode == SH_LSR)
      assert_lsr_top_clear_R3: assert (result[W-1] == 1'b0);
  end
endmodule

// File: rtl/uopalu_sbx.sv
module uopalu_sbx
  import uopalu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] xr,
  input  logic [W-1:0] imm,
  output logic [W-1:0] diff,
  output logic         no_borrow
);
  logic [W-1:0] masked;
  logic [W:0]   wide;

  assign masked    = acc & xr;
  assign wide      = sub_wide(masked, imm);
  assign diff      = wide[W-1:0];
  assign no_borrow = ~wide[W];

  always_comb begin
    assert_carry_is_compare_R7: assert (no_borrow == (masked >= imm));
    assert_diff_restores_R6: assert (W'(diff + imm) == masked);
  end
endmodule

// File: rtl/uopalu_nz.sv
module uopalu_nz #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic         neg,
  output logic         zero
);
  assign neg  = value[W-1];
  assign zero = ~|value;
endmodule

// File: rtl/uopalu_top.sv
module uopalu_top
  import uopalu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [SEL_W-1:0] op_sel,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     x_in,
  input  logic [W-1:0]     sp_in,
  input  logic             c_in,
  input  logic             n_in,
  input  logic             z_in,
  input  logic             v_in,
  input  logic             d_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     x_out,
  output logic [W-1:0]     sp_out,
  output logic             a_we,
  output logic             x_we,
  output logic             sp_we,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             v_out,
  output logic             d_out
);
  logic [W-1:0] acc_masked;
  logic [W-1:0] sp_masked;
  logic [W-1:0] x_masked;
  logic [W-1:0] shift_res;
  logic         shift_c;
  logic [W-1:0] sbx_diff;
  logic         sbx_c;
  logic [W-1:0] flag_src;
  logic         nz_n;
  logic         nz_z;
  logic         supported;
  shift_mode_e  sh_mode;

  assign acc_masked = a_in & operand;
  assign sp_masked  = sp_in & operand;
  assign x_masked   = x_in & operand;
  assign supported  = (op_sel >= OP_ANC) && (op_sel <= OP_XAA);

  always_comb begin
    case (op_sel)
      OP_ARR:  sh_mode = SH_ROT;
      OP_ASR:  sh_mode = SH_LSR;
      default: sh_mode = SH_PASS;
    endcase
  end

  uopalu_shift #(.W(W)) u_shift (
    .masked (acc_masked),
    .mode   (sh_mode),
    .result (shift_res),
    .carry  (shift_c)
  );

  uopalu_sbx #(.W(W)) u_sbx (
    .acc       (a_in),
    .xr        (x_in),
    .imm       (operand),
    .diff      (sbx_diff),
    .no_borrow (sbx_c)
  );

  uopalu_nz #(.W(W)) u_nz (
    .value (flag_src),
    .neg   (nz_n),
    .zero  (nz_z)
  );

  always_comb begin
    a_out    = a_in;
    x_out    = x_in;
    sp_out   = sp_in;
    a_we     = 1'b0;
    x_we     = 1'b0;
    sp_we    = 1'b0;
    c_out    = c_in;
    flag_src = a_in;
    case (op_sel)
      OP_ANC, OP_ARR, OP_ASR: begin
        a_out    = shift_res;
        a_we     = 1'b1;
        c_out    = shift_c;
        flag_src = shift_res;
      end
      OP_LAX: begin
        a_out    = operand;
        x_out    = operand;
        a_we     = 1'b1;
        x_we     = 1'b1;
        flag_src = operand;
      end
      OP_LAS: begin
        a_out    = sp_masked;
        x_out    = sp_masked;
        sp_out   = sp_masked;
        a_we     = 1'b1;
        x_we     = 1'b1;
        sp_we    = 1'b1;
        flag_src = sp_masked;
      end
      OP_SBX: begin
        x_out    = sbx_diff;
        x_we     = 1'b1;
        c_out    = sbx_c;
        flag_src = sbx_diff;
      end
      OP_XAA: begin
        a_out    = x_masked;
        a_we     = 1'b1;
        flag_src = x_masked;
      end
      default: ;
    endcase
  end

  assign n_out = supported ? nz_n : n_in;
  assign z_out = supported ? nz_z : z_in;
  assign v_out = v_in;
  assign d_out = d_in;

  always_comb begin
    if (!supported)
      assert_idle_quiet_R9: assert (!a_we && !x_we && !sp_we && n_out == n_in
                                    && z_out == z_in && c_out == c_in);
    assert_hold_unwritten_R12: assert ((a_we || a_out == a_in) && (x_we || x_out == x_in)
                                       && (sp_we || sp_out == sp_in));
    if (supported)
      assert_nz_tracks_R10: assert (n_out == (x_we && !a_we ? x_out[W-1] : a_out[W-1])
                                    && z_out == ((x_we && !a_we ? x_out : a_out) == '0));
    if (op_sel == OP_LAS)
      assert_las_all_R5: assert (a_we && x_we && sp_we && a_out == x_out && x_out == sp_out);
  end
endmodule

// File: tb/sim_uopalu_top.sv
module sim_uopalu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] operand = '0, a_in = '0, x_in = '0, sp_in = '0;
  logic       c_in = 0, n_in = 0, z_in = 0, v_in = 0, d_in = 0;
  logic [7:0] a_out, x_out, sp_out;
  logic       a_we, x_we, sp_we, n_out, z_out, c_out, v_out, d_out;
  int         n_tests = 0;
  int         n_fail = 0;
  int         cycles = 0;

  always #2.5 clk = ~clk;

  uopalu_top u0 (
    .op_sel(op_sel), .operand(operand), .a_in(a_in), .x_in(x_in), .sp_in(sp_in),
    .c_in(c_in), .n_in(n_in), .z_in(z_in), .v_in(v_in), .d_in(d_in),
    .a_out(a_out), .x_out(x_out), .sp_out(sp_out), .a_we(a_we), .x_we(x_we),
    .sp_we(sp_we), .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out),
    .d_out(d_out)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6/R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Independent model; packs {a,x,sp,we[3],n,z,c,v,d}
  function automatic logic [31:0] model(input logic [3:0] op, input logic [7:0] m,
      input logic [7:0] a, input logic [7:0] x, input logic [7:0] s,
      input logic c, input logic n, input logic z, input logic v, input logic d);
    logic [7:0] ea = a, ex = x, es = s, t, shown;
    logic [2:0] we = 3'b000;
    logic ec = c, en = n, ez = z;
    int diff;
    shown = 8'h00;
    case (op)
      4'd1: begin t = a & m; ea = t; ec = t[7]; we = 3'b100; shown = ea; end
      4'd2: begin t = a & m; ea = (t / 2) | (t & 8'h80); ec = t[7]; we = 3'b100; shown = ea; end
      4'd3: begin t = a & m; ea = t / 2; ec = t[0]; we = 3'b100; shown = ea; end
      4'd4: begin ea = m; ex = m; we = 3'b110; shown = m; end
      4'd5: begin t = s & m; ea = t; ex = t; es = t; we = 3'b111; shown = t; end
      4'd6: begin
        diff = int'(a & x) - int'(m);
        ex = 8'(diff + 256);
        ec = (diff >= 0);
        we = 3'b010;
        shown = ex;
      end
      4'd7: begin ea = x & m; we = 3'b100; shown = ea; end
      default: ;
    endcase
    if (op >= 4'd1 && op <= 4'd7) begin
      en = shown >= 8'h80;
      ez = shown == 8'h00;
    end
    return {ea, ex, es, we, en, ez, ec, v, d};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] m, input logic [7:0] a,
      input logic [7:0] x, input logic [7:0] s, input logic [4:0] fl, input string tag);
    logic [31:0] exp_v, got;
    @(posedge clk);
    op_sel = op; operand = m; a_in = a; x_in = x; sp_in = s;
    {c_in, n_in, z_in, v_in, d_in} = fl;
    @(negedge clk);
    exp_v = model(op, m, a, x, s, fl[4], fl[3], fl[2], fl[1], fl[0]);
    got = {a_out, x_out, sp_out, a_we, x_we, sp_we, n_out, z_out, c_out, v_out, d_out};
    n_tests++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s (R10/R11/R12) op=%0d actual=%h expected=%h",
               req_of(op), tag, op, got, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle op passes everything through (R9)
    @(negedge clk);
    n_tests++;
    if ({a_we, x_we, sp_we} !== 3'b000 || a_out !== 8'h00 || c_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 idle after reset actual=%b expected=000", {a_we, x_we, sp_we});
    end
    // directed corners
    apply(4'd6, 8'h00, 8'hF0, 8'h0F, 8'h11, 5'b00000, "R7 equal zero, c_in=0");
    apply(4'd6, 8'h01, 8'hF0, 8'h0F, 8'h11, 5'b10000, "R7 borrow, c_in=1");
    apply(4'd6, 8'h3C, 8'hFF, 8'h3C, 8'h22, 5'b10000, "R7 equal nonzero");
    apply(4'd6, 8'h3D, 8'hFF, 8'h3C, 8'h22, 5'b00011, "R6 one below, R11 v/d");
    apply(4'd2, 8'hFF, 8'h81, 8'h00, 8'h00, 5'b00000, "R2 msb and lsb set");
    apply(4'd2, 8'h7F, 8'h81, 8'h00, 8'h00, 5'b10000, "R2 msb masked");
    apply(4'd3, 8'hFF, 8'h81, 8'h00, 8'h00, 5'b00000, "R3 bit0 out");
    apply(4'd3, 8'h01, 8'h01, 8'h00, 8'h00, 5'b00100, "R3 result zero");
    apply(4'd1, 8'h80, 8'hFF, 8'h12, 8'h34, 5'b00000, "R1 result 0x80");
    apply(4'd1, 8'h0F, 8'hF0, 8'h12, 8'h34, 5'b11000, "R1 result zero");
    apply(4'd4, 8'h00, 8'h55, 8'hAA, 8'h34, 5'b10000, "R4 zero load");
    apply(4'd5, 8'hF0, 8'h01, 8'h02, 8'h8F, 5'b10000, "R5 mask SP");
    apply(4'd7, 8'hC3, 8'h00, 8'h81, 8'h34, 5'b00000, "R8 mask X");
    for (int k = 0; k < 16; k++)
      apply(4'(k), 8'hA5, 8'h5A, 8'hC3, 8'h3C, 5'b01010, "R9 R12 sweep");
    // constrained random: mostly supported ops, some unsupported
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      op = ($urandom % 4 == 0) ? 4'($urandom) : 4'(1 + $urandom % 7);
      apply(op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            5'($urandom), "random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule